// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-register transfer command into a series of single-word memory requests. A command carries a base address, a 16-bit register mask, a direction bit (increment or decrement), a timing bit (adjust before or after each access) and a writeback bit. After the command is accepted, the sequencer makes one request for each set mask bit. Each request carries the register index and the word address on a valid/ready port. When the last request has been accepted, the block reports the updated base value.

Register indices always go out in ascending order, and the lowest-numbered register always gets the lowest address. Any ordering a programmer might write in a register list therefore has no effect. Decrement modes work out their lowest address first and then step upward.

Stack disciplines map onto the four modes. A full-descending push is decrement-before and its pop is increment-after, so a push followed by a pop returns the base to its first value. A load whose mask includes register 15, the program counter, raises a branch flag together with completion.

Top module: `bts_top`

## Requirements
- R1: After reset the block is idle: busy, done, reqValid, wbValid and pcBranch are all 0.
- R2: An accepted command makes exactly one request per set mask bit. The requests go out in ascending register index, and each address is 4 above the previous one.
- R3: With incMode=1 and beforeMode=0 (increment-after), the first address equals the base.
- R4: With incMode=1 and beforeMode=1 (increment-before), the first address is base+4.
- R5: With incMode=0 and beforeMode=0 (decrement-after), the first address is base-4*n+4, where n is the number of set mask bits.
- R6: With incMode=0 and beforeMode=1 (decrement-before), the first address is base-4*n.
- R7: In the done cycle, wbValid equals the latched writeback bit. wbAddr is base+4*n for increment modes and base-4*n for decrement modes. For example, base 0x1000 with three registers gives 0x100C or 0x0FF4.
- R8: An empty mask makes no request and raises done in the cycle after acceptance, with wbAddr equal to the base.
- R9: pcBranch is 1 in the done cycle exactly when isLoad=1 and mask bit 15 is set.
- R10: While reqValid is 1 and reqReady is 0, reqValid, reqAddr and reqRegIdx hold their values into the next cycle.
- R11: A start pulse while busy=1 is ignored and does not change the transfer in progress.
- R12: busy is 1 from the cycle after acceptance through the done cycle. done lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken when not busy |
| baseAddr | input | 32 | Base address of the transfer |
| regMask | input | 16 | Registers to move, bit i = register i |
| incMode | input | 1 | 1 = increment, 0 = decrement |
| beforeMode | input | 1 | 1 = adjust before access, 0 = after |
| wbEnable | input | 1 | Request base writeback |
| isLoad | input | 1 | 1 = load, 0 = store |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| reqValid | output | 1 | Memory request valid |
| reqReady | input | 1 | Memory request accepted |
| reqAddr | output | 32 | Word address of the request |
| reqRegIdx | output | 4 | Register index of the request |
| wbValid | output | 1 | Written-back base present (with done) |
| wbAddr | output | 32 | Updated base value |
| pcBranch | output | 1 | Load included the program counter (with done) |

## Verification
The assertions check three things on every cycle. A stalled request stays frozen. Successive accepted requests rise by one word and by register index. done never lasts beyond one cycle.

Only the bench scenarios can show the rest:
- the absolute start address of each of the four modes;
- the written-back base;
- the branch flag;
- the empty-mask shortcut;
- that a start pulse while busy leaves the running sequence unchanged.

The bench compares each of these against values it computes itself, under both continuous and irregular reqReady patterns.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;
endpackage

// File: rtl/bts_datapath.sv
module bts_datapath
  import bts_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [NREG-1:0]   regMask,
  input  logic              incMode,
  input  logic              beforeMode,
  input  logic              wbEnable,
  input  logic              isLoad,
  output logic              maskLeft,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] curAddr,
  output logic [IDX_W-1:0]  curIdx,
  output logic [ADDR_W-1:0] finalBase,
  output logic              wbFlag,
  output logic              pcFlag
);
  localparam int CNT_W = IDX_W + 1;
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(WORD_BYTES);

  logic [NREG-1:0]   remMask;
  logic [NREG-1:0]   remNext;
  logic [CNT_W-1:0]  regCount;
  logic [ADDR_W-1:0] byteSpan;
  logic [ADDR_W-1:0] firstAddr;
  logic [ADDR_W-1:0] endBase;

  // population count of the incoming mask
  always_comb begin
    regCount = '0;
    for (int i = 0; i < NREG; i++) regCount = regCount + CNT_W'(regMask[i]);
  end

  assign byteSpan = ADDR_W'(regCount) << WORD_SHIFT;

  // lowest address of the block in every mode
  always_comb begin
    unique case ({incMode, beforeMode})
      2'b10:   firstAddr = baseAddr;
      2'b11:   firstAddr = baseAddr + WORD;
      2'b01:   firstAddr = baseAddr - byteSpan;
      default: firstAddr = baseAddr - byteSpan + WORD;
    endcase
    endBase = incMode ? (baseAddr + byteSpan) : (baseAddr - byteSpan);
  end

  // lowest remaining register, picked by a descending scan
  always_comb begin
    curIdx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (remMask[i]) curIdx = IDX_W'(i);
  end

  assign remNext  = remMask & (remMask - NREG'(1));
  assign maskLeft = |remMask;
  assign lastBeat = (remNext == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remMask   <= '0;
      curAddr   <= '0;
      finalBase <= '0;
      wbFlag    <= 1'b0;
      pcFlag    <= 1'b0;
    end else if (strobe.load) begin
      remMask   <= regMask;
      curAddr   <= firstAddr;
      finalBase <= endBase;
      wbFlag    <= wbEnable;
      pcFlag    <= isLoad & regMask[NREG-1];
    end else if (strobe.step) begin
      remMask   <= remNext;
      curAddr   <= curAddr + WORD;
    end
  end

  // R2
  step_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> maskLeft)
    else $error("step with no register left");

  // R2
  step_shrinks_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> ($countones(remMask) + 1 == $countones($past(remMask))))
    else $error("step did not retire exactly one register");
endmodule

// File: rtl/bts_control.sv
module bts_control
  import bts_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       maskAny,
  input  logic       lastBeat,
  input  logic       reqReady,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       reqValid
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        strobe.load = 1'b1;
        stateNext   = maskAny ? ST_RUN : ST_FIN;
      end
      ST_RUN: if (reqReady) begin
        strobe.step = 1'b1;
        if (lastBeat) stateNext = ST_FIN;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy     = (state != ST_IDLE);
  assign reqValid = (state == ST_RUN);
  assign done     = (state == ST_FIN);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done)
    else $error("done longer than one cycle");

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid)
    else $error("request withdrawn while stalled");

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |-> !strobe.load)
    else $error("command reloaded while busy");
endmodule

// File: rtl/bts_top.sv
module bts_top
  import bts_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [NREG-1:0]   regMask,
  input  logic              incMode,
  input  logic              beforeMode,
  input  logic              wbEnable,
  input  logic              isLoad,
  output logic              busy,
  output logic              done,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [IDX_W-1:0]  reqRegIdx,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic              pcBranch
);
  seqStrobe_t strobe;
  logic maskLeft, lastBeat, wbFlag, pcFlag;

  bts_control ctrl (
    .clk(clk), .rstN(rstN), .start(start), .maskAny(|regMask),
    .lastBeat(lastBeat), .reqReady(reqReady), .strobe(strobe),
    .busy(busy), .done(done), .reqValid(reqValid)
  );

  bts_datapath #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .regMask(regMask), .incMode(incMode), .beforeMode(beforeMode),
    .wbEnable(wbEnable), .isLoad(isLoad), .maskLeft(maskLeft),
    .lastBeat(lastBeat), .curAddr(reqAddr), .curIdx(reqRegIdx),
    .finalBase(wbAddr), .wbFlag(wbFlag), .pcFlag(pcFlag)
  );

  assign wbValid  = done & wbFlag;
  assign pcBranch = done & pcFlag;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqValid || (reqAddr == $past(reqAddr) + ADDR_W'(WORD_BYTES)))
    else $error("address did not advance by one word");

  // R2
  idx_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqValid || (reqRegIdx > $past(reqRegIdx)))
    else $error("register index not ascending");

  // R10
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> $stable(reqAddr) && $stable(reqRegIdx))
    else $error("request changed while stalled");

  // R9
  pc_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcBranch |-> done)
    else $error("branch flag outside completion");
endmodule

// File: tb/bts_top_test.sv
`timescale 1ns/1ps
module bts_top_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, start, incMode, beforeMode, wbEnable, isLoad, reqReady;
  logic [31:0] baseAddr;
  logic [15:0] regMask;
  logic busy, done, reqValid, wbValid, pcBranch;
  logic [31:0] reqAddr, wbAddr;
  logic [3:0] reqRegIdx;

  bts_top uut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .regMask(regMask),
    .incMode(incMode), .beforeMode(beforeMode), .wbEnable(wbEnable), .isLoad(isLoad),
    .busy(busy), .done(done), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqRegIdx(reqRegIdx), .wbValid(wbValid), .wbAddr(wbAddr),
    .pcBranch(pcBranch)
  );

  typedef struct { logic [3:0] idx; logic [31:0] addr; } item_t;
  item_t expQ[$];
  int tests = 0, fails = 0;
  string curTag = "R2";
  logic expWbValid, expPc, doneSeen, stallMode;
  logic [31:0] expWbAddr;
  logic [7:0] lfsr = 8'h5A;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ready pattern, changed shortly after each rising edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    reqReady = stallMode ? lfsr[0] : 1'b1;
  end

  // monitor: pop the scoreboard at every handshake, check completion
  always @(negedge clk) begin
    if (rstN) begin
      if (reqValid && reqReady) begin
        if (expQ.size() == 0) check({curTag, " extra request"}, {28'd0, reqRegIdx}, 32'hFFFF_FFFF);
        else begin
          item_t it;
          it = expQ.pop_front();
          check({curTag, " R2 index"}, {28'd0, reqRegIdx}, {28'd0, it.idx});
          check({curTag, " address"}, reqAddr, it.addr);
        end
      end
      if (done) begin
        check("R7 wbValid", {31'd0, wbValid}, {31'd0, expWbValid});
        check("R7 wbAddr", wbAddr, expWbAddr);
        check("R9 pcBranch", {31'd0, pcBranch}, {31'd0, expPc});
        check("R2 all requests made", expQ.size(), 0);
        doneSeen = 1'b1;
      end
    end
  end

  task automatic runOp(string tag, logic [31:0] base, logic [15:0] mask,
                       logic inc, logic bef, logic wb, logic ld, logic interfere);
    int n = 0;
    logic [31:0] a;
    int guard = 0;
    for (int i = 0; i < 16; i++) if (mask[i]) n++;
    if (inc) a = bef ? base + 32'd4 : base;
    else     a = bef ? base - 32'(4 * n) : base - 32'(4 * n) + 32'd4;
    for (int i = 0; i < 16; i++) if (mask[i]) begin
      item_t it;
      it.idx = 4'(i); it.addr = a;
      expQ.push_back(it);
      a = a + 32'd4;
    end
    expWbValid = wb;
    expWbAddr  = inc ? base + 32'(4 * n) : base - 32'(4 * n);
    expPc      = ld & mask[15];
    curTag     = tag;
    doneSeen   = 1'b0;
    @(negedge clk);
    baseAddr = base; regMask = mask; incMode = inc; beforeMode = bef;
    wbEnable = wb; isLoad = ld; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R12 busy after accept", {31'd0, busy}, 32'd1);
    if (mask == 16'd0) check("R8 done next cycle", {31'd0, done}, 32'd1);
    if (interfere && busy) begin
      // R11: a conflicting command while busy must change nothing
      baseAddr = 32'h0; regMask = 16'hFFFF; incMode = 1'b0; beforeMode = 1'b1;
      wbEnable = 1'b0; isLoad = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!doneSeen && guard < 2000) begin @(posedge clk); guard++; end
    if (!doneSeen) check({tag, " completion"}, 32'd0, 32'd1);
    @(negedge clk);
    check("R12 done one cycle", {31'd0, done}, 32'd0);
    check("R12 idle after done", {31'd0, busy}, 32'd0);
    expQ.delete();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; baseAddr = '0; regMask = '0; incMode = 1'b0;
    beforeMode = 1'b0; wbEnable = 1'b0; isLoad = 1'b0; reqReady = 1'b1; stallMode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 reqValid", {31'd0, reqValid}, 32'd0);
    check("R1 wbValid/pcBranch", {30'd0, wbValid, pcBranch}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    runOp("R3", 32'h1000, 16'h0023, 1, 0, 1, 0, 0);
    runOp("R4", 32'h1000, 16'h0023, 1, 1, 1, 0, 0);
    runOp("R5", 32'h1000, 16'h0023, 0, 0, 1, 1, 0);
    runOp("R6", 32'h1000, 16'h0023, 0, 1, 1, 1, 0);
    stallMode = 1'b1;
    runOp("R10 R6", 32'h2000, 16'hFFFF, 0, 1, 1, 0, 0);
    runOp("R10 R3", 32'h3F00, 16'h8421, 1, 0, 0, 1, 0);
    runOp("R11 R4", 32'h0400, 16'h0C30, 1, 1, 1, 0, 1);
    stallMode = 1'b0;
    runOp("R8", 32'h5550, 16'h0000, 1, 0, 1, 1, 0);
    runOp("R9 store", 32'h6000, 16'h8001, 0, 0, 0, 0, 0);
    runOp("R9 load", 32'h6000, 16'h8001, 1, 1, 1, 1, 0);
    // full-descending push then pop returns to the first base (R7)
    runOp("R7 push", 32'h8000, 16'h4007, 0, 1, 1, 0, 0);
    runOp("R7 pop", 32'h7FF0, 16'h4007, 1, 0, 1, 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule